// File: doc/BRIEF.md
# Complete-Split Eligibility Checker

This block decides, one descriptor at a time, whether a split isochronous IN transfer that is in its complete-split phase may issue a complete-split in the current microframe. A descriptor reaches this phase only after its start-split has been sent. The scheduler presents the descriptor's complete mask and complete progress mask. It also gives the one-hot bit and the 3-bit index of the current microframe, plus a flag that says whether the descriptor was just fetched from the schedule or was reached by following a back pointer.

Two tests decide the outcome. The schedule test ANDs the current-microframe bit with the complete mask; an empty result means nothing is scheduled now, so the descriptor is skipped. The progress test checks that every complete-split scheduled in an earlier microframe of the frame has already been recorded in the progress mask. If it has not, a microframe was missed and the descriptor must be retired, meaning its active flag is cleared. The order of the tests depends on the microframe index. For the first two microframes of a frame, a freshly fetched descriptor cannot run the progress test until the back-pointer descriptor has been fetched. The block then holds a wait flag until a resolved strobe arrives. When a complete-split is issued, the block returns the progress mask with the current microframe's bit added.

Top module: `csplit_elig`

## Requirements
- R1: Each outcome is registered and appears on exactly one of `issue_o`, `skip_o` or `retire_o` for one cycle. It comes one clock after the request, or one clock after the resolving strobe. In any other cycle all three are low.
- R2: When the current-microframe bit ANDed with the complete mask is zero, the next cycle shows `skip_o`, `wait_bp_o` stays low and `prog_o` equals the presented progress mask. This holds for any index.
- R3: When the schedule test passes and either the index is 2 or more or `fresh_i` is low, both tests are applied in the same cycle and the outcome appears on the next cycle, with no wait.
- R4: When the schedule test passes, `fresh_i` is high and the index is 0 or 1, the next cycle shows `wait_bp_o` high and no outcome.
- R5: While `wait_bp_o` is high and `bp_resolved_i` is low, the block stays waiting, issues nothing and ignores new requests.
- R6: A `bp_resolved_i` pulse while waiting applies the progress test to the stored descriptor. On the next cycle it gives `issue_o` or `retire_o`, and `wait_bp_o` drops.
- R7: The progress test passes when every complete-mask bit at a position below the current index is also set in the progress mask. If it fails, the outcome is `retire_o`, and `prog_o` equals the progress mask unchanged.
- R8: On `issue_o`, `prog_o` equals the progress mask OR the current-microframe bit. `prog_o` holds its value between outcomes.
- R9: A `bp_resolved_i` pulse while not waiting has no effect: no outcome, no wait, `prog_o` unchanged.
- R10: After reset, `issue_o`, `skip_o`, `retire_o` and `wait_bp_o` are low and `prog_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Evaluate the presented descriptor this cycle |
| fresh_i | input | 1 | High: freshly fetched; low: reached through a back pointer |
| uf_bit_i | input | 8 | One-hot current-microframe bit |
| uf_idx_i | input | 3 | Current microframe index |
| cmask_i | input | 8 | Complete mask of the descriptor |
| cprog_i | input | 8 | Complete progress mask of the descriptor |
| bp_resolved_i | input | 1 | Back-pointer descriptor has been fetched |
| issue_o | output | 1 | Issue a complete-split |
| skip_o | output | 1 | Nothing scheduled in this microframe |
| retire_o | output | 1 | Microframe missed; clear the active flag |
| wait_bp_o | output | 1 | Decision deferred until back-pointer resolution |
| prog_o | output | 8 | Updated progress mask |

## Verification
The assertions check on every cycle the timing and ordering. A failed schedule test always skips. Early fresh descriptors always enter the wait. Late or back-pointer-reached descriptors never wait. A held wait never issues. A strobe always releases the wait into an issue or a retire, and at most one outcome is ever active. Only the bench scenarios show the values: which lower complete-mask bits the progress test demands, the exact updated progress mask, and that the outcome after a wait uses the stored descriptor and not the requests ignored while waiting.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
    localparam int UF_PER_FRAME = 8;
    localparam int UF_IDX_W     = $clog2(UF_PER_FRAME);
    localparam int DEFER_BELOW  = 2;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_ISSUE  = 2'd1,
        OUT_SKIP   = 2'd2,
        OUT_RETIRE = 2'd3
    } outcome_e;
endpackage

// File: rtl/csplit_sched_test.sv
module csplit_sched_test #(
    parameter int UF_N = 8
) (
    input  logic [UF_N-1:0] uf_bit,
    input  logic [UF_N-1:0] cmask,
    output logic            scheduled
);
    assign scheduled = |(uf_bit & cmask);
endmodule

// File: rtl/csplit_progress_test.sv
module csplit_progress_test #(
    parameter int UF_N  = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [UF_N-1:0]  cmask,
    input  logic [UF_N-1:0]  cprog,
    output logic             complete
);
    logic [UF_N-1:0] earlier;

    // one comparator per microframe position: is it before the current one
    for (genvar g = 0; g < UF_N; g++) begin : g_earlier
        assign earlier[g] = (IDX_W'(g) < idx);
    end

    assign complete = ((cmask & earlier & ~cprog) == '0);
endmodule

// File: rtl/csplit_defer_sel.sv
module csplit_defer_sel #(
    parameter int IDX_W     = 3,
    parameter int DEFER_LIM = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             fresh,
    output logic             defer
);
    assign defer = fresh && (int'(idx) < DEFER_LIM);
endmodule

// File: rtl/csplit_elig.sv
module csplit_elig
    import csplit_pkg::*;
#(
    parameter int UF_N      = UF_PER_FRAME,
    parameter int DEFER_LIM = DEFER_BELOW,
    localparam int IDX_W    = $clog2(UF_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             fresh_i,
    input  logic [UF_N-1:0]  uf_bit_i,
    input  logic [IDX_W-1:0] uf_idx_i,
    input  logic [UF_N-1:0]  cmask_i,
    input  logic [UF_N-1:0]  cprog_i,
    input  logic             bp_resolved_i,
    output logic             issue_o,
    output logic             skip_o,
    output logic             retire_o,
    output logic             wait_bp_o,
    output logic [UF_N-1:0]  prog_o
);
    typedef struct packed {
        logic             waiting;
        logic [IDX_W-1:0] idx;
        logic [UF_N-1:0]  ubit;
        logic [UF_N-1:0]  cmask;
        logic [UF_N-1:0]  cprog;
        logic [UF_N-1:0]  prog;
        outcome_e         outcome;
    } state_t;

    state_t st_d, st_q;

    logic live_sched, live_done, live_defer, held_done;

    csplit_sched_test #(.UF_N(UF_N)) u_sched (
        .uf_bit    (uf_bit_i),
        .cmask     (cmask_i),
        .scheduled (live_sched)
    );

    csplit_progress_test #(.UF_N(UF_N), .IDX_W(IDX_W)) u_prog_live (
        .idx      (uf_idx_i),
        .cmask    (cmask_i),
        .cprog    (cprog_i),
        .complete (live_done)
    );

    csplit_progress_test #(.UF_N(UF_N), .IDX_W(IDX_W)) u_prog_held (
        .idx      (st_q.idx),
        .cmask    (st_q.cmask),
        .cprog    (st_q.cprog),
        .complete (held_done)
    );

    csplit_defer_sel #(.IDX_W(IDX_W), .DEFER_LIM(DEFER_LIM)) u_defer (
        .idx   (uf_idx_i),
        .fresh (fresh_i),
        .defer (live_defer)
    );

    always_comb begin
        st_d         = st_q;
        st_d.outcome = OUT_NONE;
        if (st_q.waiting) begin
            if (bp_resolved_i) begin
                st_d.waiting = 1'b0;
                if (held_done) begin
                    st_d.outcome = OUT_ISSUE;
                    st_d.prog    = st_q.cprog | st_q.ubit;
                end else begin
                    st_d.outcome = OUT_RETIRE;
                    st_d.prog    = st_q.cprog;
                end
            end
        end else if (req_i) begin
            if (!live_sched) begin
                st_d.outcome = OUT_SKIP;
                st_d.prog    = cprog_i;
            end else if (live_defer) begin
                st_d.waiting = 1'b1;
                st_d.idx     = uf_idx_i;
                st_d.ubit    = uf_bit_i;
                st_d.cmask   = cmask_i;
                st_d.cprog   = cprog_i;
            end else if (live_done) begin
                st_d.outcome = OUT_ISSUE;
                st_d.prog    = cprog_i | uf_bit_i;
            end else begin
                st_d.outcome = OUT_RETIRE;
                st_d.prog    = cprog_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_o   = (st_q.outcome == OUT_ISSUE);
    assign skip_o    = (st_q.outcome == OUT_SKIP);
    assign retire_o  = (st_q.outcome == OUT_RETIRE);
    assign wait_bp_o = st_q.waiting;
    assign prog_o    = st_q.prog;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_o, skip_o, retire_o})); // R1
    AST_UNSCHEDULED_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wait_bp_o && ((uf_bit_i & cmask_i) == '0)) |=> (skip_o && !wait_bp_o)); // R2
    AST_LATE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wait_bp_o && (!fresh_i || int'(uf_idx_i) >= DEFER_LIM))
        |=> (!wait_bp_o && (issue_o || skip_o || retire_o))); // R3
    AST_EARLY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wait_bp_o && fresh_i && int'(uf_idx_i) < DEFER_LIM
         && ((uf_bit_i & cmask_i) != '0))
        |=> (wait_bp_o && !issue_o && !skip_o && !retire_o)); // R4
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_bp_o && !bp_resolved_i) |=> (wait_bp_o && !issue_o && !skip_o && !retire_o)); // R5
    AST_STROBE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_bp_o && bp_resolved_i) |=> (!wait_bp_o && (issue_o || retire_o))); // R6
    AST_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_bp_o && !req_i && bp_resolved_i)
        |=> (!wait_bp_o && !issue_o && !retire_o && !skip_o && $stable(prog_o))); // R9
endmodule

// File: tb/tb_csplit_elig.sv
`timescale 1ns/1ps
module tb_csplit_elig;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_i, fresh_i, bp_resolved_i;
    logic [7:0] uf_bit_i, cmask_i, cprog_i;
    logic [2:0] uf_idx_i;
    logic       issue_o, skip_o, retire_o, wait_bp_o;
    logic [7:0] prog_o;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    csplit_elig dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .fresh_i(fresh_i),
        .uf_bit_i(uf_bit_i), .uf_idx_i(uf_idx_i), .cmask_i(cmask_i),
        .cprog_i(cprog_i), .bp_resolved_i(bp_resolved_i),
        .issue_o(issue_o), .skip_o(skip_o), .retire_o(retire_o),
        .wait_bp_o(wait_bp_o), .prog_o(prog_o)
    );

    // outcome code: 4 issue, 2 skip, 1 retire, 0 none
    function automatic int code();
        return {issue_o, skip_o, retire_o};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive after a falling edge, then sample at the following falling edge
    task automatic cycle(input logic req, input logic fresh, input int idx,
                         input logic [7:0] cm, input logic [7:0] cp, input logic bp);
        req_i = req; fresh_i = fresh; uf_idx_i = 3'(idx);
        uf_bit_i = 8'(1 << idx); cmask_i = cm; cprog_i = cp; bp_resolved_i = bp;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; bp_resolved_i = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b0);
        chk(tag, code(), 0);
    endtask

    task automatic t_skip();
        cycle(1'b1, 1'b1, 3, 8'h01, 8'h5A, 1'b0);
        chk("R2 skip outcome", code(), 2);
        chk("R2 skip prog", prog_o, 8'h5A);
        chk("R2 no wait", wait_bp_o, 0);
        idle_check("R1 pulse clears");
        cycle(1'b1, 1'b1, 0, 8'h02, 8'h00, 1'b0);
        chk("R2 early skip no wait", {wait_bp_o, skip_o}, 1);
    endtask

    task automatic t_late();
        cycle(1'b1, 1'b1, 4, 8'h3C, 8'h0C, 1'b0);
        chk("R3 late issue", code(), 4);
        chk("R8 late prog", prog_o, 8'h1C);
        cycle(1'b1, 1'b1, 4, 8'h1C, 8'h04, 1'b0);
        chk("R7 missed bit3 retire", code(), 1);
        chk("R7 retire prog", prog_o, 8'h04);
        cycle(1'b1, 1'b1, 6, 8'h41, 8'h00, 1'b0);
        chk("R7 missed bit0 retire", code(), 1);
        cycle(1'b1, 1'b0, 1, 8'h03, 8'h01, 1'b0);
        chk("R3 back-pointer early issue", {wait_bp_o, issue_o}, 1);
        chk("R8 back-pointer prog", prog_o, 8'h03);
    endtask

    task automatic t_defer_issue();
        cycle(1'b1, 1'b1, 1, 8'h03, 8'h01, 1'b0);
        chk("R4 wait raised", {wait_bp_o, 3'(code())}, 8);
        cycle(1'b1, 1'b1, 5, 8'h01, 8'hFF, 1'b0);
        chk("R5 request ignored", {wait_bp_o, 3'(code())}, 8);
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b0);
        chk("R5 still waiting", {wait_bp_o, 3'(code())}, 8);
        chk("R5 prog untouched", prog_o, 8'h03);
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b1);
        chk("R6 issue after strobe", {wait_bp_o, 3'(code())}, 4);
        chk("R8 deferred prog", prog_o, 8'h03);
    endtask

    task automatic t_defer_retire();
        cycle(1'b1, 1'b1, 1, 8'h03, 8'h00, 1'b0);
        chk("R4 wait raised idx1", wait_bp_o, 1);
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b1);
        chk("R6 retire after strobe", {wait_bp_o, 3'(code())}, 1);
        chk("R7 deferred retire prog", prog_o, 8'h00);
        cycle(1'b1, 1'b1, 0, 8'h81, 8'h40, 1'b0);
        chk("R4 wait raised idx0", wait_bp_o, 1);
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b1);
        chk("R6 idx0 issue", code(), 4);
        chk("R8 idx0 prog", prog_o, 8'h41);
    endtask

    task automatic t_stray();
        cycle(1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b1);
        chk("R9 stray strobe outcome", {wait_bp_o, 3'(code())}, 0);
        chk("R9 stray strobe prog", prog_o, 8'h41);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL R1 watchdog expired actual=0x1 expected=0x0");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; fresh_i = 1'b0; bp_resolved_i = 1'b0;
        uf_bit_i = '0; uf_idx_i = '0; cmask_i = '0; cprog_i = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset outcome", {wait_bp_o, 3'(code())}, 0);
        chk("R10 reset prog", prog_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_skip();
        t_late();
        t_defer_issue();
        t_defer_retire();
        t_stray();
        idle_check("R1 idle");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule